// File: doc/BRIEF.md
# DDR SDRAM Command Sequence Monitor

This block watches the command pins of a four-bank DDR SDRAM device without driving anything. On every rising clock edge it decodes the command from chip select, the three strobes RAS/CAS/WE, the bank-address pair, the auto-precharge address bit and the clock-enable level. It compares the clock-enable level with the power state it is already tracking. It keeps a model of which banks hold an open row. It also tracks the programmed burst length, the quiet window that follows a mode-register write, the read/write lockout that follows a write with auto-precharge, and the power state: running, active power-down, precharge power-down or self-refresh.

Any command that breaks the sequencing rules sets a sticky error flag and records a code that names the rule broken. An illegal command leaves the bank model untouched, so one mistake does not produce a cascade of follow-on errors. The monitor is placed beside a memory controller in simulation or in silicon debug logic. Software or a bench reads the flag and clears it through a synchronous clear input.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With csN high the edge is a deselect: it is always legal and changes no state. With csN low and {rasN,casN,weN}=011 (activate), the bank given by ba opens. Bank n is bit n of bankOpen, so ba=0 is bit 0 and ba=3 is bit 3.
- R2: Precharge ({rasN,casN,weN}=010) with a10=0 closes the bank given by ba. With a10=1 it closes every bank and ba is ignored. Precharging an idle bank is legal.
- R3: Read (101) or write (100) to an open bank is legal. With a10=1 the bank is idle after that edge. With a10=0 it stays open.
- R4: A mode-register write (000) is legal only when all banks are idle; otherwise errCode=1. With ba=0 it loads the burst length from modeAddr: 001 gives 2, 010 gives 4, 011 gives 8, and any other value keeps the old length. With ba nonzero (extended register) the burst length is unchanged. After reset the burst length is 2.
- R5: After a legal mode-register write at edge N, any command other than NOP or deselect at edge N+1 or N+2, with cke high, gives errCode=3. Edge N+3 is free.
- R6: Refresh (001) with cke high is legal only when all banks are idle; otherwise errCode=2.
- R7: After a write with a10=1 at edge N, a read or write to any bank at edges N+1 to N+BL/2 gives errCode=6. From edge N+BL/2+1 such commands are legal again.
- R8: Burst stop (110) is legal at any burst length and changes no state.
- R9: While running, cke low with a NOP or deselect enters power-down: pwrMode=1 if any bank is open, pwrMode=2 if all are idle. The mode holds while cke stays low. The edge where cke is high again returns pwrMode to 0, and its command is not decoded. Bank state is kept.
- R10: While running, refresh with cke low enters self-refresh (pwrMode=3) if all banks are idle. Otherwise it gives errCode=2 and pwrMode=1. Exit is as in R9.
- R11: A read or write to an idle bank gives errCode=5. An activate to an open bank gives errCode=4. An illegal command never changes the bank state.
- R12: After reset every bank is idle, pwrMode=0, errFlag=0 and errCode=0. errFlag is sticky, and errCode keeps the first error seen. A synchronous errClear zeroes both and wins over an error in the same edge.
- R13: While running, cke low with any command other than NOP, deselect or refresh gives errCode=7. It still enters power-down as in R9, and the command has no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; commands sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| errClear | input | 1 | Synchronous clear of errFlag and errCode |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| modeAddr | input | 3 | Address bits 2..0, burst-length field on mode writes |
| bankOpen | output | 4 | One bit per bank, set while a row is open |
| pwrMode | output | 2 | 0 run, 1 active power-down, 2 precharge power-down, 3 self-refresh |
| errFlag | output | 1 | Sticky error indicator |
| errCode | output | 4 | Code of the first error since clear |

## Verification
Every output is a register, so a command sampled at one rising edge shows its effect on bankOpen, pwrMode, errFlag and errCode right after that edge and is checked at the following falling edge. The bench drives each command on a falling edge and samples before the next rising edge, so each check sees exactly one new command. The quiet window after a mode write and the write lockout are counted in sampling edges from the edge that took the opening command. The bench places its probes at the last forbidden edge and the first free edge of each window.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BL_MAX    = 8;
  localparam int BL_W      = $clog2(BL_MAX + 1);
  localparam int BL_RESET  = 2;
  localparam int MRS_GAP   = 2;
  localparam int GAP_W     = $clog2(MRS_GAP + 1);
  localparam int LOCK_W    = $clog2(BL_MAX / 2 + 1);
  localparam int ERR_W     = 4;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } rcw_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_ACTPD = 2'd1,
    PWR_PREPD = 2'd2,
    PWR_SELF  = 2'd3
  } pwr_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE     = 4'd0,
    ERR_MRS_BUSY = 4'd1,
    ERR_REF_BUSY = 4'd2,
    ERR_GAP      = 4'd3,
    ERR_ACT_OPEN = 4'd4,
    ERR_RW_IDLE  = 4'd5,
    ERR_LOCK     = 4'd6,
    ERR_CKE_CMD  = 4'd7
  } errCode_e;

  typedef struct packed {
    logic              actStb;
    logic              closeStb;
    logic              closeAll;
    logic [BANK_W-1:0] bank;
    logic              blLoad;
    logic [BL_W-1:0]   blVal;
    logic              gapStart;
    logic              lockStart;
    logic              errStb;
    errCode_e          errCode;
  } strobe_t;
endpackage

// File: rtl/ddr_mon_ctrl.sv
module ddr_mon_ctrl
  import ddr_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 a10,
  input  logic [2:0]           modeAddr,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 gapBusy,
  input  logic                 lockBusy,
  output strobe_t              stb,
  output pwr_e                 pwrMode
);

  function automatic logic [BL_W-1:0] blDecode(input logic [2:0] field);
    case (field)
      3'b001:  return BL_W'(2);
      3'b010:  return BL_W'(4);
      3'b011:  return BL_W'(8);
      default: return '0;
    endcase
  endfunction

  rcw_e            cmd;
  pwr_e            pwrNext;
  pwr_e            pdTarget;
  logic            quietCmd;
  logic            allIdle;
  logic            selOpen;
  logic            isRdWr;
  logic [BL_W-1:0] blCode;

  always_comb begin
    cmd      = rcw_e'({rasN, casN, weN});
    quietCmd = csN | (cmd == CMD_NOP);
    isRdWr   = !csN && (cmd == CMD_RD || cmd == CMD_WR);
    allIdle  = (bankOpen == '0);
    selOpen  = bankOpen[ba];
    pdTarget = allIdle ? PWR_PREPD : PWR_ACTPD;
    blCode   = blDecode(modeAddr);
    stb      = '0;
    stb.bank = ba;
    pwrNext  = pwrMode;

    if (pwrMode != PWR_RUN) begin
      if (cke) pwrNext = PWR_RUN;
    end else if (!cke) begin
      if (quietCmd) begin
        pwrNext = pdTarget;
      end else if (cmd == CMD_REF) begin
        if (allIdle) begin
          pwrNext = PWR_SELF;
        end else begin
          pwrNext     = PWR_ACTPD;
          stb.errStb  = 1'b1;
          stb.errCode = ERR_REF_BUSY;
        end
      end else begin
        pwrNext     = pdTarget;
        stb.errStb  = 1'b1;
        stb.errCode = ERR_CKE_CMD;
      end
    end else if (!quietCmd) begin
      if (gapBusy) begin
        stb.errStb  = 1'b1;
        stb.errCode = ERR_GAP;
      end else begin
        case (cmd)
          CMD_MRS: begin
            if (!allIdle) begin
              stb.errStb  = 1'b1;
              stb.errCode = ERR_MRS_BUSY;
            end else begin
              stb.gapStart = 1'b1;
              if (ba == '0 && blCode != '0) begin
                stb.blLoad = 1'b1;
                stb.blVal  = blCode;
              end
            end
          end
          CMD_REF: begin
            if (!allIdle) begin
              stb.errStb  = 1'b1;
              stb.errCode = ERR_REF_BUSY;
            end
          end
          CMD_ACT: begin
            if (selOpen) begin
              stb.errStb  = 1'b1;
              stb.errCode = ERR_ACT_OPEN;
            end else begin
              stb.actStb = 1'b1;
            end
          end
          CMD_RD, CMD_WR: begin
            if (lockBusy) begin
              stb.errStb  = 1'b1;
              stb.errCode = ERR_LOCK;
            end else if (!selOpen) begin
              stb.errStb  = 1'b1;
              stb.errCode = ERR_RW_IDLE;
            end else if (a10) begin
              stb.closeStb  = 1'b1;
              stb.lockStart = (cmd == CMD_WR);
            end
          end
          CMD_PRE: begin
            if (a10) stb.closeAll = 1'b1;
            else     stb.closeStb = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwrMode <= PWR_RUN;
    else        pwrMode <= pwrNext;
  end

  assert_mrs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.gapStart |-> (bankOpen == '0));

  assert_act_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stb.actStb |-> !bankOpen[stb.bank]);

  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrMode != PWR_RUN && !cke) |=> (pwrMode == $past(pwrMode)));

  assert_lock_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockBusy && cke && pwrMode == PWR_RUN && !gapBusy && isRdWr) |-> (stb.errStb && !stb.closeStb));

endmodule

// File: rtl/ddr_mon_dpath.sv
module ddr_mon_dpath
  import ddr_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 errClear,
  input  strobe_t              stb,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 gapBusy,
  output logic                 lockBusy,
  output logic                 errFlag,
  output errCode_e             errCode
);

  logic [BL_W-1:0]   burstLen;
  logic [GAP_W-1:0]  gapCnt;
  logic [LOCK_W-1:0] lockCnt;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit = (stb.bank == BANK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     bankOpen[i] <= 1'b0;
      else if (stb.closeAll)          bankOpen[i] <= 1'b0;
      else if (stb.closeStb && hit)   bankOpen[i] <= 1'b0;
      else if (stb.actStb && hit)     bankOpen[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          burstLen <= BL_W'(BL_RESET);
    else if (stb.blLoad) burstLen <= stb.blVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gapCnt <= '0;
    else if (stb.gapStart) gapCnt <= GAP_W'(MRS_GAP);
    else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lockCnt <= '0;
    else if (stb.lockStart) lockCnt <= LOCK_W'(burstLen >> 1);
    else if (lockCnt != '0) lockCnt <= lockCnt - 1'b1;
  end

  assign gapBusy  = (gapCnt != '0);
  assign lockBusy = (lockCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
    end else if (errClear) begin
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
    end else if (stb.errStb && !errFlag) begin
      errFlag <= 1'b1;
      errCode <= stb.errCode;
    end
  end

  assert_close_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.closeAll |=> (bankOpen == '0));

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb.actStb |=> bankOpen[$past(stb.bank)]);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !errClear) |=> (errFlag && $stable(errCode)));

  assert_burst_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burstLen == BL_W'(2)) || (burstLen == BL_W'(4)) || (burstLen == BL_W'(8)));

  assert_illegal_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.errStb && !stb.closeAll && !stb.closeStb && !stb.actStb) |=> $stable(bankOpen));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 errClear,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 a10,
  input  logic [2:0]           modeAddr,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [1:0]           pwrMode,
  output logic                 errFlag,
  output logic [ERR_W-1:0]     errCode
);

  strobe_t  stb;
  pwr_e     pwrState;
  errCode_e errState;
  logic     gapBusy;
  logic     lockBusy;

  ddr_mon_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .a10      (a10),
    .modeAddr (modeAddr),
    .bankOpen (bankOpen),
    .gapBusy  (gapBusy),
    .lockBusy (lockBusy),
    .stb      (stb),
    .pwrMode  (pwrState)
  );

  ddr_mon_dpath u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .errClear (errClear),
    .stb      (stb),
    .bankOpen (bankOpen),
    .gapBusy  (gapBusy),
    .lockBusy (lockBusy),
    .errFlag  (errFlag),
    .errCode  (errState)
  );

  assign pwrMode = pwrState;
  assign errCode = errState;

endmodule

// File: tb/ddr_cmd_monitor_bench.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_bench;
  localparam logic [2:0] RC_MRS = 3'b000, RC_REF = 3'b001, RC_PRE = 3'b010, RC_ACT = 3'b011;
  localparam logic [2:0] RC_WR  = 3'b100, RC_RD  = 3'b101, RC_BST = 3'b110, RC_NOP = 3'b111;
  localparam int NV = 26;

  // {clr, cke, csN, rcw, ba, a10, mode, expOpen, expPwr, expErr, expCode}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_ACT,2'd1,1'b0,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_ACT,2'd3,1'b0,3'd0,4'b1010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_RD ,2'd1,1'b0,3'd0,4'b1010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_WR ,2'd3,1'b1,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_RD ,2'd1,1'b0,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_BST,2'd0,1'b0,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b1,RC_MRS,2'd0,1'b0,3'd0,4'b0010,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_PRE,2'd1,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_MRS,2'd0,1'b0,3'd3,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b1,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_REF,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_ACT,2'd0,1'b0,3'd0,4'b0001,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_ACT,2'd2,1'b0,3'd0,4'b0101,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_PRE,2'd3,1'b1,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b0,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd2,1'b0,4'd0},
    {1'b0,1'b0,1'b1,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd2,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_ACT,2'd2,1'b0,3'd0,4'b0100,2'd0,1'b0,4'd0},
    {1'b0,1'b0,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0100,2'd1,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_RD ,2'd2,1'b1,3'd0,4'b0100,2'd0,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_PRE,2'd0,1'b1,3'd0,4'b0000,2'd0,1'b0,4'd0},
    {1'b0,1'b0,1'b0,RC_REF,2'd0,1'b0,3'd0,4'b0000,2'd3,1'b0,4'd0},
    {1'b0,1'b1,1'b0,RC_NOP,2'd0,1'b0,3'd0,4'b0000,2'd0,1'b0,4'd0}
  };

  string vecTag [NV] = '{"R1","R1","R1","R3","R3","R7","R7","R8","R1","R2","R4","R5","R5",
                         "R6","R1","R1","R2","R9","R9","R9","R1","R9","R9","R2","R10","R10"};

  logic clk = 1'b0;
  logic rst_n, errClear, cke, csN, rasN, casN, weN, a10, errFlag;
  logic [1:0] ba, pwrMode;
  logic [2:0] modeAddr;
  logic [3:0] bankOpen, errCode;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .errClear(errClear), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .a10(a10), .modeAddr(modeAddr),
    .bankOpen(bankOpen), .pwrMode(pwrMode), .errFlag(errFlag), .errCode(errCode)
  );

  task automatic step(input logic clr, input logic k, input logic cs, input logic [2:0] rcw,
                      input logic [1:0] b, input logic ap, input logic [2:0] md);
    errClear = clr; cke = k; csN = cs; {rasN, casN, weN} = rcw; ba = b; a10 = ap; modeAddr = md;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(input logic [2:0] rcw, input logic [1:0] b, input logic ap);
    step(1'b0, 1'b1, 1'b0, rcw, b, ap, 3'd0);
  endtask

  task automatic clearErr();
    step(1'b1, 1'b1, 1'b0, RC_NOP, 2'd0, 1'b0, 3'd0);
  endtask

  task automatic expect_state(input string tag, input logic [3:0] eo, input logic [1:0] ep,
                              input logic ee, input logic [3:0] ec);
    checks++;
    if ({bankOpen, pwrMode, errFlag, errCode} !== {eo, ep, ee, ec}) begin
      fails++;
      $display("FAIL %s: open=%b pwr=%0d err=%b code=%0d expected open=%b pwr=%0d err=%b code=%0d",
               tag, bankOpen, pwrMode, errFlag, errCode, eo, ep, ee, ec);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    errClear = 1'b0; cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = RC_NOP;
    ba = 2'd0; a10 = 1'b0; modeAddr = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_state("R12 reset", 4'b0000, 2'd0, 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:17], VEC[i][16:15], VEC[i][14], VEC[i][13:11]);
      expect_state($sformatf("%s vector %0d", vecTag[i], i), VEC[i][10:7], VEC[i][6:5], VEC[i][4], VEC[i][3:0]);
    end

    // R4: mode write with an open bank
    op(RC_ACT, 2'd0, 1'b0);
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd0, 1'b0, 3'd2);
    expect_state("R4 mode write busy", 4'b0001, 2'd0, 1'b1, 4'd1);
    op(RC_RD, 2'd3, 1'b0);
    expect_state("R12 first code kept", 4'b0001, 2'd0, 1'b1, 4'd1);
    clearErr();
    expect_state("R12 clear", 4'b0001, 2'd0, 1'b0, 4'd0);

    // R11: idle read, open activate
    op(RC_RD, 2'd3, 1'b1);
    expect_state("R11 read idle bank", 4'b0001, 2'd0, 1'b1, 4'd5);
    clearErr();
    op(RC_ACT, 2'd0, 1'b0);
    expect_state("R11 activate open bank", 4'b0001, 2'd0, 1'b1, 4'd4);
    clearErr();

    // R6 / R10 / R13
    op(RC_REF, 2'd0, 1'b0);
    expect_state("R6 refresh busy", 4'b0001, 2'd0, 1'b1, 4'd2);
    clearErr();
    step(1'b0, 1'b0, 1'b0, RC_REF, 2'd0, 1'b0, 3'd0);
    expect_state("R10 self refresh busy", 4'b0001, 2'd1, 1'b1, 4'd2);
    clearErr();
    expect_state("R10 exit", 4'b0001, 2'd0, 1'b0, 4'd0);
    step(1'b0, 1'b0, 1'b0, RC_ACT, 2'd2, 1'b0, 3'd0);
    expect_state("R13 command at cke fall", 4'b0001, 2'd1, 1'b1, 4'd7);
    clearErr();
    expect_state("R13 exit", 4'b0001, 2'd0, 1'b0, 4'd0);

    // R2: precharge of an idle bank
    op(RC_PRE, 2'd2, 1'b0);
    expect_state("R2 precharge idle bank", 4'b0001, 2'd0, 1'b0, 4'd0);
    op(RC_PRE, 2'd1, 1'b1);
    expect_state("R2 precharge all", 4'b0000, 2'd0, 1'b0, 4'd0);

    // R5: quiet window after a mode write
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd0, 1'b0, 3'd3);
    op(RC_ACT, 2'd0, 1'b0);
    expect_state("R5 command at N+1", 4'b0000, 2'd0, 1'b1, 4'd3);
    clearErr();
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd0, 1'b0, 3'd3);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_ACT, 2'd1, 1'b0);
    expect_state("R5 command at N+2", 4'b0000, 2'd0, 1'b1, 4'd3);
    clearErr();
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd0, 1'b0, 3'd3);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_ACT, 2'd1, 1'b0);
    expect_state("R5 command at N+3", 4'b0010, 2'd0, 1'b0, 4'd0);

    // R7: burst length 8 lockout of four edges
    op(RC_ACT, 2'd0, 1'b0);
    op(RC_WR, 2'd0, 1'b1);
    expect_state("R3 write auto-precharge", 4'b0010, 2'd0, 1'b0, 4'd0);
    repeat (4) op(RC_NOP, 2'd0, 1'b0);
    op(RC_WR, 2'd1, 1'b0);
    expect_state("R7 write at N+5 legal", 4'b0010, 2'd0, 1'b0, 4'd0);
    op(RC_ACT, 2'd0, 1'b0);
    op(RC_WR, 2'd0, 1'b1);
    repeat (3) op(RC_NOP, 2'd0, 1'b0);
    op(RC_RD, 2'd1, 1'b0);
    expect_state("R7 read at N+4 locked", 4'b0010, 2'd0, 1'b1, 4'd6);
    clearErr();

    // R4: extended write keeps burst length 8
    op(RC_PRE, 2'd0, 1'b1);
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd1, 1'b0, 3'd1);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_ACT, 2'd0, 1'b0);
    op(RC_ACT, 2'd1, 1'b0);
    op(RC_WR, 2'd0, 1'b1);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_WR, 2'd1, 1'b0);
    expect_state("R4 extended write keeps length", 4'b0010, 2'd0, 1'b1, 4'd6);
    clearErr();

    // R4: burst length 2 gives a one-edge lockout
    op(RC_PRE, 2'd0, 1'b1);
    step(1'b0, 1'b1, 1'b0, RC_MRS, 2'd0, 1'b0, 3'd1);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_ACT, 2'd0, 1'b0);
    op(RC_ACT, 2'd1, 1'b0);
    op(RC_WR, 2'd0, 1'b1);
    op(RC_NOP, 2'd0, 1'b0);
    op(RC_WR, 2'd1, 1'b0);
    expect_state("R4 burst length 2 loaded", 4'b0010, 2'd0, 1'b0, 4'd0);

    // R12: clear beats a same-edge error
    step(1'b1, 1'b1, 1'b0, RC_RD, 2'd3, 1'b0, 3'd0);
    expect_state("R12 clear priority", 4'b0010, 2'd0, 1'b0, 4'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule